// File: doc/BRIEF.md
# Hashed Station-Address Lookup Engine

This block answers exact-match queries on 48-bit station addresses for a bridging data path. Each query key is reduced to a 16-bit CRC, and the low bits of that CRC pick one slot in a bucket-head table. The head slot points into a shared entry store. Keys that land in the same bucket are kept as a singly linked chain inside that store. A lookup walks the chain one node per clock cycle and compares the full 48-bit key at every node. It stops on the first match, or when it reaches the end of the chain. The answer is a hit flag together with the forwarding port stored for that key.

The same request port also takes insert commands. An insert claims the next unused entry and places the new key in front of the existing chain for its bucket. Because insertion always goes to the front, a key inserted again overrides its older copy. The response time of a lookup grows with the number of chain nodes that must be visited. A requester issues one command at a time through a valid/ready handshake and waits for the single-cycle completion pulse.

Top module: `mac_hash_lookup`

## Requirements
- R1: After reset, req_ready is 1, rsp_done, rsp_hit and full are 0, and every bucket is empty, so any lookup misses.
- R2: A command is taken on a rising edge where req_valid and req_ready are both 1. req_ready is 1 only while no command is in progress, and req_valid raised while a command is in progress has no effect.
- R3: The bucket index is the low 6 bits of a CRC-16 over the key. The polynomial is 0x8005 and the initial value is 0. Key bit 47 is fed first, with no bit reflection and no final inversion. Keys with equal index share one chain.
- R4: A lookup whose key sits at chain position k (1 = bucket head) raises rsp_done exactly k+1 cycles after the accepting edge, with rsp_hit=1 and rsp_port equal to the stored port.
- R5: A lookup whose key is absent from a bucket holding L entries raises rsp_done exactly L+2 cycles after the accepting edge, with rsp_hit=0 and rsp_port=0.
- R6: A command with req_op=1 is an insert. It raises rsp_done one cycle after the accepting edge, with rsp_hit=1 when the entry was stored. The new entry becomes the head of its bucket chain.
- R7: When a key is inserted a second time with a different port, later lookups of that key return the most recently inserted port.
- R8: full rises together with the completion of the insert that fills the last entry (16 by default) and then stays 1. An insert while full completes one cycle after acceptance with rsp_hit=0 and stores nothing.
- R9: rsp_done is a one-cycle pulse, and rsp_hit and rsp_port are 0 whenever rsp_done is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Engine idle and able to take a command |
| req_op | input | 1 | 0 = lookup, 1 = insert |
| req_key | input | 48 | Station address to search for or store |
| req_port | input | 4 | Port to store on insert |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_hit | output | 1 | Lookup found the key / insert was stored |
| rsp_port | output | 4 | Port of the matching entry |
| full | output | 1 | No unused entry left |

## Verification
An insert completes one cycle after it is accepted. A lookup hit at chain position k completes after k+1 cycles, and a miss over a chain of L nodes completes after L+2 cycles. The bench counts falling edges from the accepting edge until rsp_done appears, and compares that count against the value each vector expects. It checks hit, port and full on that same falling edge. It finds colliding keys with its own CRC model, so chain positions and latencies are known ahead of each command.

// File: rtl/mhl_pkg.sv
package mhl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HEAD   = 2'd1,
        ST_WALK   = 2'd2,
        ST_INSERT = 2'd3
    } mhl_state_e;

    localparam logic OP_LOOKUP = 1'b0;
    localparam logic OP_INSERT = 1'b1;

endpackage

// File: rtl/mhl_crc16.sv
module mhl_crc16 #(
    parameter int          DATA_W = 48,
    parameter int          CRC_W  = 16,
    parameter logic [15:0] POLY   = 16'h8005,
    parameter int          OUT_W  = 6
) (
    input  logic [DATA_W-1:0] data,
    output logic [OUT_W-1:0]  idx
);

    logic [CRC_W-1:0] crc;
    logic             fb;

    always_comb begin
        crc = '0;
        fb  = 1'b0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb  = crc[CRC_W-1] ^ data[i];
            crc = {crc[CRC_W-2:0], 1'b0};
            if (fb) begin
                crc = crc ^ POLY[CRC_W-1:0];
            end
        end
        idx = crc[OUT_W-1:0];
    end

endmodule

// File: rtl/mhl_head_table.sv
module mhl_head_table #(
    parameter int BKT_W = 6,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BKT_W-1:0] addr,
    output logic             rd_vld,
    output logic [IDX_W-1:0] rd_idx,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx
);

    localparam int BUCKETS = 1 << BKT_W;

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
    } head_t;

    head_t heads_d [BUCKETS];
    head_t heads_q [BUCKETS];

    always_comb begin
        for (int b = 0; b < BUCKETS; b++) begin
            heads_d[b] = heads_q[b];
        end
        if (we) begin
            heads_d[addr].vld = 1'b1;
            heads_d[addr].idx = wr_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < BUCKETS; b++) begin
                heads_q[b] <= '0;
            end
        end else begin
            for (int b = 0; b < BUCKETS; b++) begin
                heads_q[b] <= heads_d[b];
            end
        end
    end

    assign rd_vld = heads_q[addr].vld;
    assign rd_idx = heads_q[addr].idx;

endmodule

// File: rtl/mhl_entry_store.sv
module mhl_entry_store #(
    parameter int KEY_W   = 48,
    parameter int PORT_W  = 4,
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic              rd_vld,
    output logic [KEY_W-1:0]  rd_key,
    output logic [PORT_W-1:0] rd_port,
    output logic              rd_nxt_vld,
    output logic [IDX_W-1:0]  rd_nxt_idx,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [KEY_W-1:0]  wr_key,
    input  logic [PORT_W-1:0] wr_port,
    input  logic              wr_nxt_vld,
    input  logic [IDX_W-1:0]  wr_nxt_idx
);

    typedef struct packed {
        logic              vld;
        logic [KEY_W-1:0]  key;
        logic [PORT_W-1:0] port;
        logic              nxt_vld;
        logic [IDX_W-1:0]  nxt_idx;
    } node_t;

    node_t mem_d [ENTRIES];
    node_t mem_q [ENTRIES];

    always_comb begin
        for (int e = 0; e < ENTRIES; e++) begin
            mem_d[e] = mem_q[e];
        end
        if (we) begin
            mem_d[wr_addr].vld     = 1'b1;
            mem_d[wr_addr].key     = wr_key;
            mem_d[wr_addr].port    = wr_port;
            mem_d[wr_addr].nxt_vld = wr_nxt_vld;
            mem_d[wr_addr].nxt_idx = wr_nxt_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                mem_q[e] <= '0;
            end
        end else begin
            for (int e = 0; e < ENTRIES; e++) begin
                mem_q[e] <= mem_d[e];
            end
        end
    end

    assign rd_vld     = mem_q[rd_addr].vld;
    assign rd_key     = mem_q[rd_addr].key;
    assign rd_port    = mem_q[rd_addr].port;
    assign rd_nxt_vld = mem_q[rd_addr].nxt_vld;
    assign rd_nxt_idx = mem_q[rd_addr].nxt_idx;

endmodule

// File: rtl/mac_hash_lookup.sv
module mac_hash_lookup
    import mhl_pkg::*;
#(
    parameter int          KEY_W    = 48,
    parameter int          PORT_W   = 4,
    parameter int          BKT_W    = 6,
    parameter int          ENTRIES  = 16,
    parameter logic [15:0] CRC_POLY = 16'h8005
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_op,
    input  logic [KEY_W-1:0]  req_key,
    input  logic [PORT_W-1:0] req_port,
    output logic              rsp_done,
    output logic              rsp_hit,
    output logic [PORT_W-1:0] rsp_port,
    output logic              full
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int CNT_W = $clog2(ENTRIES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(ENTRIES);

    typedef struct packed {
        mhl_state_e        st;
        logic [KEY_W-1:0]  key;
        logic [PORT_W-1:0] port;
        logic [BKT_W-1:0]  bkt;
        logic              cur_vld;
        logic [IDX_W-1:0]  cur_idx;
        logic [CNT_W-1:0]  used;
        logic              done;
        logic              hit;
        logic [PORT_W-1:0] rport;
    } ctl_t;

    ctl_t r_d, r_q;

    logic [BKT_W-1:0]  hash_idx;
    logic              head_vld;
    logic [IDX_W-1:0]  head_idx;
    logic              head_we;
    logic              ent_vld;
    logic [KEY_W-1:0]  ent_key;
    logic [PORT_W-1:0] ent_port;
    logic              ent_nxt_vld;
    logic [IDX_W-1:0]  ent_nxt_idx;
    logic              ent_we;
    logic [IDX_W-1:0]  alloc_idx;

    mhl_crc16 #(
        .DATA_W (KEY_W),
        .CRC_W  (16),
        .POLY   (CRC_POLY),
        .OUT_W  (BKT_W)
    ) i_hash (
        .data (req_key),
        .idx  (hash_idx)
    );

    mhl_head_table #(
        .BKT_W (BKT_W),
        .IDX_W (IDX_W)
    ) i_heads (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (r_q.bkt),
        .rd_vld (head_vld),
        .rd_idx (head_idx),
        .we     (head_we),
        .wr_idx (alloc_idx)
    );

    mhl_entry_store #(
        .KEY_W   (KEY_W),
        .PORT_W  (PORT_W),
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_addr    (r_q.cur_idx),
        .rd_vld     (ent_vld),
        .rd_key     (ent_key),
        .rd_port    (ent_port),
        .rd_nxt_vld (ent_nxt_vld),
        .rd_nxt_idx (ent_nxt_idx),
        .we         (ent_we),
        .wr_addr    (alloc_idx),
        .wr_key     (r_q.key),
        .wr_port    (r_q.port),
        .wr_nxt_vld (head_vld),
        .wr_nxt_idx (head_idx)
    );

    assign alloc_idx = r_q.used[IDX_W-1:0];

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.hit   = 1'b0;
        r_d.rport = '0;
        head_we   = 1'b0;
        ent_we    = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.key  = req_key;
                    r_d.port = req_port;
                    r_d.bkt  = hash_idx;
                    r_d.st   = (req_op == OP_INSERT) ? ST_INSERT : ST_HEAD;
                end
            end
            ST_HEAD: begin
                r_d.cur_vld = head_vld;
                r_d.cur_idx = head_idx;
                r_d.st      = ST_WALK;
            end
            ST_WALK: begin
                if (!r_q.cur_vld) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else if (ent_vld && (ent_key == r_q.key)) begin
                    r_d.done  = 1'b1;
                    r_d.hit   = 1'b1;
                    r_d.rport = ent_port;
                    r_d.st    = ST_IDLE;
                end else begin
                    r_d.cur_vld = ent_nxt_vld;
                    r_d.cur_idx = ent_nxt_idx;
                end
            end
            ST_INSERT: begin
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
                if (r_q.used != CNT_MAX) begin
                    r_d.hit  = 1'b1;
                    ent_we   = 1'b1;
                    head_we  = 1'b1;
                    r_d.used = r_q.used + 1'b1;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign rsp_done  = r_q.done;
    assign rsp_hit   = r_q.hit;
    assign rsp_port  = r_q.rport;
    assign full      = (r_q.used == CNT_MAX);

endmodule

// File: rtl/mhl_checker.sv
module mhl_checker #(
    parameter int PORT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              rsp_hit,
    input logic [PORT_W-1:0] rsp_port,
    input logic              full
);

    AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !rsp_done)); // R2

    AST_DONE_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready); // R4

    AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R9

    AST_QUIET_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_done |-> (!rsp_hit && (rsp_port == '0))); // R9

    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> full); // R8

    AST_FULL_WITH_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> (rsp_done && rsp_hit)); // R8

endmodule

bind mac_hash_lookup mhl_checker #(
    .PORT_W (PORT_W)
) i_mhl_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .rsp_hit   (rsp_hit),
    .rsp_port  (rsp_port),
    .full      (full)
);

// File: tb/test_mac_hash_lookup.sv
module test_mac_hash_lookup;

    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES    = 16;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_op = 1'b0;
    logic [47:0] req_key = '0;
    logic [3:0]  req_port = '0;
    logic        rsp_done;
    logic        rsp_hit;
    logic [3:0]  rsp_port;
    logic        full;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    mac_hash_lookup i_mac_hash_lookup (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_key   (req_key),
        .req_port  (req_port),
        .rsp_done  (rsp_done),
        .rsp_hit   (rsp_hit),
        .rsp_port  (rsp_port),
        .full      (full)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // stimulus slots: 0..2 collide, 3 collides but is never stored, 4 is elsewhere
    typedef struct packed {
        logic       op;
        logic [2:0] slot;
        logic [3:0] port;
        logic       exp_hit;
        logic [3:0] exp_port;
        logic [3:0] exp_lat;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 3'd0, 4'd0,  1'b0, 4'd0,  4'd2},  // R5 empty bucket
        '{1'b1, 3'd0, 4'd3,  1'b1, 4'd0,  4'd1},  // R6
        '{1'b0, 3'd0, 4'd0,  1'b1, 4'd3,  4'd2},  // R4 head
        '{1'b1, 3'd1, 4'd5,  1'b1, 4'd0,  4'd1},  // R6
        '{1'b1, 3'd2, 4'd9,  1'b1, 4'd0,  4'd1},  // R6
        '{1'b0, 3'd2, 4'd0,  1'b1, 4'd9,  4'd2},  // R4 pos 1
        '{1'b0, 3'd1, 4'd0,  1'b1, 4'd5,  4'd3},  // R3 pos 2
        '{1'b0, 3'd0, 4'd0,  1'b1, 4'd3,  4'd4},  // R3 pos 3
        '{1'b0, 3'd3, 4'd0,  1'b0, 4'd0,  4'd5},  // R5 miss over 3
        '{1'b0, 3'd4, 4'd0,  1'b0, 4'd0,  4'd2},  // R3 other bucket empty
        '{1'b1, 3'd4, 4'd7,  1'b1, 4'd0,  4'd1},  // R6
        '{1'b0, 3'd4, 4'd0,  1'b1, 4'd7,  4'd2},  // R4
        '{1'b1, 3'd1, 4'd12, 1'b1, 4'd0,  4'd1},  // R7 re-insert
        '{1'b0, 3'd1, 4'd0,  1'b1, 4'd12, 4'd2},  // R7 newest wins
        '{1'b0, 3'd0, 4'd0,  1'b1, 4'd3,  4'd5}   // R4 pos 4
    };

    logic [47:0] slots [5];

    function automatic logic [5:0] bucket_of(input logic [47:0] k);
        logic [15:0] c;
        logic        f;
        c = '0;
        for (int i = 47; i >= 0; i--) begin
            f = c[15] ^ k[i];
            c = {c[14:0], 1'b0};
            if (f) c = c ^ 16'h8005;
        end
        return c[5:0];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // called at a falling edge with the engine idle; returns at the falling edge showing rsp_done
    task automatic do_req(input logic op, input logic [47:0] key, input logic [3:0] port,
                          output logic hit, output logic [3:0] rp, output int lat,
                          output bit busy_ok);
        req_valid = 1'b1;
        req_op    = op;
        req_key   = key;
        req_port  = port;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat       = 0;
        busy_ok   = 1'b1;
        while (!rsp_done && lat < 100) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        hit = rsp_hit;
        rp  = rsp_port;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            check(1'b0, "R2", "watchdog expired", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        logic       hit;
        logic [3:0] rp;
        int         lat;
        bit         busy_ok;
        int         cnt;
        logic [5:0] tgt;
        logic [47:0] ykey;
        logic [47:0] fill_key;

        // find colliding keys with the bench CRC model (R3)
        slots[0] = 48'h02AB_CD00_0000;
        tgt      = bucket_of(slots[0]);
        cnt      = 1;
        slots[4] = '0;
        for (int i = 1; i < 20000 && cnt < 4; i++) begin
            if (bucket_of(slots[0] + 48'(i)) == tgt) begin
                slots[cnt] = slots[0] + 48'(i);
                cnt++;
            end else if (slots[4] == '0) begin
                slots[4] = slots[0] + 48'(i);
            end
        end

        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        check(rsp_done == 1'b0, "R1", "done after reset", rsp_done, 0);
        check(full == 1'b0, "R1", "full after reset", full, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            do_req(VECS[v].op, slots[VECS[v].slot], VECS[v].port, hit, rp, lat, busy_ok);
            check(lat == int'(VECS[v].exp_lat), "R4/R5/R6", $sformatf("vec %0d latency", v),
                  lat, VECS[v].exp_lat);
            check(hit == VECS[v].exp_hit, "R4/R5/R6", $sformatf("vec %0d hit", v),
                  hit, VECS[v].exp_hit);
            check(rp == VECS[v].exp_port, "R4/R7", $sformatf("vec %0d port", v),
                  rp, VECS[v].exp_port);
            check(busy_ok, "R2", $sformatf("vec %0d ready low while busy", v), 0, 1);
            @(negedge clk);
            check(rsp_done == 1'b0, "R9", "done lasts one cycle", rsp_done, 0);
        end

        // R2: a request raised while busy is ignored
        ykey      = 48'h0AAA_5555_0001;
        req_valid = 1'b1;
        req_op    = 1'b0;
        req_key   = slots[0];
        @(posedge clk);
        @(negedge clk);
        req_op   = 1'b1;
        req_key  = ykey;
        req_port = 4'd6;
        while (!rsp_done) @(negedge clk);
        req_valid = 1'b0;
        check(rsp_hit == 1'b1 && rsp_port == 4'd3, "R2", "busy lookup result", rsp_port, 3);
        @(negedge clk);
        do_req(1'b0, ykey, 4'd0, hit, rp, lat, busy_ok);
        check(hit == 1'b0, "R2", "request during busy stored nothing", hit, 0);

        // R8: fill the remaining entries (5 used so far)
        fill_key = '0;
        for (int j = 0; j < ENTRIES - 5; j++) begin
            @(negedge clk);
            fill_key = 48'h0600_0000_0000 + 48'(j);
            do_req(1'b1, fill_key, 4'(j), hit, rp, lat, busy_ok);
            check(hit == 1'b1 && lat == 1, "R6", "fill insert stored", lat, 1);
            if (j == ENTRIES - 6) begin
                check(full == 1'b1, "R8", "full with last insert", full, 1);
            end else begin
                check(full == 1'b0, "R8", "not yet full", full, 0);
            end
        end
        @(negedge clk);
        do_req(1'b1, 48'h0BBB_0000_0777, 4'd2, hit, rp, lat, busy_ok);
        check(hit == 1'b0, "R8", "insert rejected when full", hit, 0);
        check(lat == 1, "R8", "rejected insert latency", lat, 1);
        check(full == 1'b1, "R8", "full stays set", full, 1);
        @(negedge clk);
        do_req(1'b0, 48'h0BBB_0000_0777, 4'd0, hit, rp, lat, busy_ok);
        check(hit == 1'b0, "R8", "rejected key absent", hit, 0);
        @(negedge clk);
        do_req(1'b0, fill_key, 4'd0, hit, rp, lat, busy_ok);
        check(hit == 1'b1 && rp == 4'(ENTRIES - 6), "R8", "last stored key found",
              rp, ENTRIES - 6);

        // R1: reset clears the table
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(full == 1'b0 && req_ready == 1'b1, "R1", "state in reset", full, 0);
        rst_n = 1'b1;
        @(negedge clk);
        do_req(1'b0, slots[0], 4'd0, hit, rp, lat, busy_ok);
        check(hit == 1'b0 && lat == 2, "R1", "table empty after reset", lat, 2);

        @(negedge clk);
        finish_run();
    end

endmodule